// File: doc/BRIEF.md
# Triggered Compare Timer with Waveform Output

This block is an up-counting timer with a period limit register and a compare threshold register. From these it drives one waveform pin. In the repeating mode this pin carries a PWM signal. In the one-pulse mode it carries a single pulse. In the latched mode the pin stays high after the first compare match. An 8-bit configuration word chooses the following:

- where count steps come from: every clock, or rising edges of an external count pin;
- whether writes to the limit and threshold registers apply at once or wait for the end of the period;
- whether the waveform is inverted;
- what starts the count: a software command, or selected edges of an external trigger pin;
- whether a trigger that arrives mid-run restarts the count.

Software reaches the block through a four-entry write port:

- address 0: configuration word, accepted only while the timer is off;
- address 1: control (bit 0 enable, bit 1 software start);
- address 2: period limit;
- address 3: compare threshold.

Both external pins pass through a two-stage synchronizer. Their edges are found by comparing the synchronized value with its value one cycle earlier.

Top module: `trig_timer`

## Requirements
- R1: After reset, and at every cycle while enable (control bit 0) is 0, `countVal` is 0 and `running` is 0. After reset, `updFlag` and `waveOut` are 0.
- R2: With count source bit 0 of the configuration word at 0, a running counter goes up by one each clock. On the step taken while it equals the limit, it goes to 0 instead, and `updFlag` is 1 for that one cycle.
- R3: With configuration bit 0 at 1, the counter steps only on rising edges of `extCount`. The step shows in `countVal` three clock edges after the pin rises. Falling edges and a steady high level do not step it.
- R4: Configuration bits 6:5 pick the start source:
  - 0: a control write with bits 1 and 0 set starts the count;
  - 1: a rising edge of `extTrig` starts it;
  - 2: a falling edge starts it;
  - 3: either edge starts it.

  A trigger start clears the counter and raises `running` three edges after the pin changes. A software start is ignored unless the field is 0, and edges that are not selected are ignored.
- R5: With retrigger bit 4 at 1, a selected trigger edge during a run clears the counter, and counting goes on from 0. With bit 4 at 0, that edge leaves the count unaffected.
- R6: The compare result is 1 while the threshold < count ≤ limit. In repeating mode, `waveOut` equals that result, XORed with polarity bit 2.
- R7: With latched-mode bit 3 at 1, `waveOut` turns active (not equal to the polarity bit) at the first compare match. It stays active across later periods until enable is cleared.
- R8: With one-pulse bit 7 at 1, the step that wraps the counter also drops `running`. The counter then holds 0 until the next start.
- R9: With preload bit 1 at 0, a limit write applies at the closing edge of the write. With bit 1 at 1, the write is held and loaded at the next period end. A write that lands on a period-end edge waits until the period end after that one.
- R10: A configuration write made while enable is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 configuration, 1 control, 2 limit, 3 threshold |
| wrData | input | CNT_W | Write data |
| extCount | input | 1 | External count pulses (asynchronous) |
| extTrig | input | 1 | External start trigger (asynchronous) |
| waveOut | output | 1 | Waveform output |
| updFlag | output | 1 | One-cycle pulse at each period end |
| running | output | 1 | Counter is started |
| countVal | output | CNT_W | Present counter value |

## Verification
Register writes take effect at the clock edge that closes the write. A change on `extTrig` or `extCount` acts on the third rising edge after it: two synchronizer stages, then the edge compare feeds the counter logic. `updFlag` rises on the same edge that returns the counter to 0. `waveOut` is decoded from registered state, so it follows `countVal` within the same cycle. The bench changes inputs on falling edges and counts falling edges from each stimulus to the cycle in which a result is due, then samples there. Where a stimulus should have no effect, the bench compares against the value the counter would have reached had it been ignored.

// File: rtl/trig_timer_pkg.sv
`timescale 1ns/1ps
package trig_timer_pkg;

  typedef enum logic [1:0] {
    TRG_SOFT = 2'd0,
    TRG_RISE = 2'd1,
    TRG_FALL = 2'd2,
    TRG_ANY  = 2'd3
  } trig_sel_e;

  // configuration word, MSB first: bit7 .. bit0
  typedef struct packed {
    logic      onePulse;
    trig_sel_e trigSel;
    logic      retrig;
    logic      setOnce;
    logic      polInv;
    logic      preload;
    logic      countSrc;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_ARR  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CMP  = 2'd3;

  // control-to-datapath strobes
  typedef struct packed {
    logic cntClr;
    logic cntStep;
    logic wrap;
    logic wrArr;
    logic wrCmp;
    logic preload;
    logic clrOnce;
  } strb_t;

endpackage

// File: rtl/trig_timer_ctrl.sv
`timescale 1ns/1ps
module trig_timer_ctrl
  import trig_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CFG_W-1:0]  wrData,
  input  logic              extCount,
  input  logic              extTrig,
  input  logic              atArr,
  output cfg_t              cfg,
  output logic              enabled,
  output logic              running,
  output strb_t             strb
);

  localparam int N_IN = 2;
  localparam int IDX_TRIG = 0;
  localparam int IDX_CNT  = 1;

  logic [N_IN-1:0] rawIn;
  logic [N_IN-1:0] syncOut;
  logic [N_IN-1:0] syncPrev;
  logic [N_IN-1:0] riseEdge;
  logic [N_IN-1:0] fallEdge;

  assign rawIn[IDX_TRIG] = extTrig;
  assign rawIn[IDX_CNT]  = extCount;

  genvar g;
  generate
    for (g = 0; g < N_IN; g++) begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          chain       <= '0;
          syncPrev[g] <= 1'b0;
        end else begin
          chain       <= {chain[SYNC_STAGES-2:0], rawIn[g]};
          syncPrev[g] <= chain[SYNC_STAGES-1];
        end
      end
      assign syncOut[g]  = chain[SYNC_STAGES-1];
      assign riseEdge[g] = syncOut[g] & ~syncPrev[g];
      assign fallEdge[g] = ~syncOut[g] & syncPrev[g];
    end
  endgenerate

  cfg_t cfgQ;
  logic enQ;
  logic runQ;

  logic wrCfg;
  logic wrCtrl;
  logic enNext;
  logic swStart;
  logic trigEv;
  logic startEv;
  logic restart;
  logic stepNow;
  logic wrapNow;
  logic runNext;

  assign wrCfg  = wrEn && (wrAddr == ADDR_CFG) && !enQ;
  assign wrCtrl = wrEn && (wrAddr == ADDR_CTRL);
  assign enNext = wrCtrl ? wrData[0] : enQ;

  assign swStart = wrCtrl && wrData[0] && wrData[1] && (cfgQ.trigSel == TRG_SOFT);

  always_comb begin
    trigEv = 1'b0;
    unique case (cfgQ.trigSel)
      TRG_SOFT: trigEv = 1'b0;
      TRG_RISE: trigEv = riseEdge[IDX_TRIG];
      TRG_FALL: trigEv = fallEdge[IDX_TRIG];
      TRG_ANY:  trigEv = riseEdge[IDX_TRIG] | fallEdge[IDX_TRIG];
      default:  trigEv = 1'b0;
    endcase
    trigEv = trigEv && enQ;
  end

  assign startEv = swStart || trigEv;
  assign restart = startEv && enNext && (!runQ || cfgQ.retrig);
  assign stepNow = runQ && enNext && !restart &&
                   (cfgQ.countSrc ? riseEdge[IDX_CNT] : 1'b1);
  assign wrapNow = stepNow && atArr;

  always_comb begin
    runNext = runQ;
    if (!enNext)                        runNext = 1'b0;
    else if (restart)                   runNext = 1'b1;
    else if (wrapNow && cfgQ.onePulse)  runNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= '0;
      enQ  <= 1'b0;
      runQ <= 1'b0;
    end else begin
      if (wrCfg) cfgQ <= cfg_t'(wrData);
      enQ  <= enNext;
      runQ <= runNext;
    end
  end

  always_comb begin
    strb.cntClr  = restart || !enNext;
    strb.cntStep = stepNow;
    strb.wrap    = wrapNow;
    strb.wrArr   = wrEn && (wrAddr == ADDR_ARR);
    strb.wrCmp   = wrEn && (wrAddr == ADDR_CMP);
    strb.preload = cfgQ.preload;
    strb.clrOnce = !enNext;
  end

  assign cfg     = cfgQ;
  assign enabled = enQ;
  assign running = runQ;

endmodule

// File: rtl/trig_timer_dp.sv
`timescale 1ns/1ps
module trig_timer_dp
  import trig_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strb_t            strb,
  input  logic [CNT_W-1:0] wrData,
  input  logic             polInv,
  input  logic             setOnce,
  output logic             atArr,
  output logic             waveOut,
  output logic             updFlag,
  output logic [CNT_W-1:0] countVal
);

  localparam logic [CNT_W-1:0] ARR_RST = '1;
  localparam logic [CNT_W-1:0] CMP_RST = '0;

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] arrQ;
  logic [CNT_W-1:0] cmpQ;
  logic [CNT_W-1:0] arrShadow;
  logic [CNT_W-1:0] cmpShadow;
  logic             arrPend;
  logic             cmpPend;
  logic             onceQ;
  logic             updQ;
  logic             cmpHit;
  logic             activeLvl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      updQ <= 1'b0;
    end else begin
      updQ <= strb.wrap;
      if (strb.cntClr)       cntQ <= '0;
      else if (strb.wrap)    cntQ <= '0;
      else if (strb.cntStep) cntQ <= cntQ + 1'b1;
    end
  end

  // limit register with optional deferred load
  always_ff @(posedge clk) begin
    if (!rstN) begin
      arrQ      <= ARR_RST;
      arrShadow <= ARR_RST;
      arrPend   <= 1'b0;
    end else if (strb.wrArr && !strb.preload) begin
      arrQ    <= wrData;
      arrPend <= 1'b0;
    end else if (strb.wrArr) begin
      arrShadow <= wrData;
      arrPend   <= 1'b1;
    end else if (strb.wrap && arrPend) begin
      arrQ    <= arrShadow;
      arrPend <= 1'b0;
    end
  end

  // threshold register with optional deferred load
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpQ      <= CMP_RST;
      cmpShadow <= CMP_RST;
      cmpPend   <= 1'b0;
    end else if (strb.wrCmp && !strb.preload) begin
      cmpQ    <= wrData;
      cmpPend <= 1'b0;
    end else if (strb.wrCmp) begin
      cmpShadow <= wrData;
      cmpPend   <= 1'b1;
    end else if (strb.wrap && cmpPend) begin
      cmpQ    <= cmpShadow;
      cmpPend <= 1'b0;
    end
  end

  assign cmpHit = (cntQ > cmpQ) && (cntQ <= arrQ);

  always_ff @(posedge clk) begin
    if (!rstN)             onceQ <= 1'b0;
    else if (strb.clrOnce) onceQ <= 1'b0;
    else if (cmpHit)       onceQ <= 1'b1;
  end

  assign activeLvl = setOnce ? (cmpHit || onceQ) : cmpHit;
  assign waveOut   = activeLvl ^ polInv;
  assign atArr     = (cntQ == arrQ);
  assign updFlag   = updQ;
  assign countVal  = cntQ;

endmodule

// File: rtl/trig_timer.sv
`timescale 1ns/1ps
module trig_timer
  import trig_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              extCount,
  input  logic              extTrig,
  output logic              waveOut,
  output logic              updFlag,
  output logic              running,
  output logic [CNT_W-1:0]  countVal
);

  cfg_t  cfg;
  strb_t strb;
  logic  enabled;
  logic  atArr;

  trig_timer_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData[CFG_W-1:0]),
    .extCount (extCount),
    .extTrig  (extTrig),
    .atArr    (atArr),
    .cfg      (cfg),
    .enabled  (enabled),
    .running  (running),
    .strb     (strb)
  );

  trig_timer_dp #(
    .CNT_W(CNT_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .polInv   (cfg.polInv),
    .setOnce  (cfg.setOnce),
    .atArr    (atArr),
    .waveOut  (waveOut),
    .updFlag  (updFlag),
    .countVal (countVal)
  );

endmodule

// File: rtl/trig_timer_chk.sv
`timescale 1ns/1ps
module trig_timer_chk
  import trig_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             enabled,
  input logic             running,
  input cfg_t             cfg,
  input logic [CNT_W-1:0] countVal,
  input logic             waveOut,
  input logic             updFlag
);

  // R1
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |-> (countVal == '0) && !running);

  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    updFlag |-> (countVal == '0));

  // R6
  zero_count_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (countVal == '0) && !cfg.setOnce |-> (waveOut == cfg.polInv));

  // R7
  latched_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.setOnce && enabled && (waveOut != cfg.polInv))
      |=> (!enabled || (waveOut != cfg.polInv)));

  // R8
  one_pulse_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    updFlag && cfg.onePulse |-> !running);

  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(enabled) |-> $stable(cfg));

endmodule

bind trig_timer trig_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .enabled  (enabled),
  .running  (running),
  .cfg      (cfg),
  .countVal (countVal),
  .waveOut  (waveOut),
  .updFlag  (updFlag)
);

// File: tb/test_trig_timer.sv
`timescale 1ns/1ps
module test_trig_timer;

  localparam int CNT_W = 16;
  localparam int WATCHDOG = 150000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [1:0]       wrAddr = '0;
  logic [CNT_W-1:0] wrData = '0;
  logic             extCount = 1'b0;
  logic             extTrig = 1'b0;
  logic             waveOut;
  logic             updFlag;
  logic             running;
  logic [CNT_W-1:0] countVal;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trig_timer #(.CNT_W(CNT_W)) i_trig_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extCount(extCount), .extTrig(extTrig), .waveOut(waveOut),
    .updFlag(updFlag), .running(running), .countVal(countVal)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog R1..: actual=%0d cycles expected<%0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    wrEn = 1'b1; wrAddr = a; wrData = CNT_W'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // R1
  task automatic testReset();
    chk("R1", "reset count", int'(countVal), 0);
    chk("R1", "reset running", int'(running), 0);
    chk("R1", "reset upd", int'(updFlag), 0);
    chk("R1", "reset wave", int'(waveOut), 0);
  endtask

  // R2 R6
  task automatic testPwm();
    wr(0, 0); wr(2, 5); wr(3, 2); wr(1, 3);
    for (int k = 0; k < 14; k++) begin
      int c = k % 6;
      chk("R2", "pwm count", int'(countVal), c);
      chk("R2", "pwm upd", int'(updFlag), (k > 0 && c == 0) ? 1 : 0);
      chk("R6", "pwm wave", int'(waveOut), (c > 2 && c <= 5) ? 1 : 0);
      tick(1);
    end
    wr(1, 0);
    chk("R1", "off count", int'(countVal), 0);
  endtask

  // R6 polarity
  task automatic testPolarity();
    wr(0, 4); wr(1, 3);
    for (int k = 0; k < 7; k++) begin
      int c = k % 6;
      chk("R6", "inverted wave", int'(waveOut), (c > 2 && c <= 5) ? 0 : 1);
      tick(1);
    end
    wr(1, 0);
    chk("R6", "idle inverted", int'(waveOut), 1);
  endtask

  // R3
  task automatic testExtCount();
    wr(0, 1); wr(2, 1000); wr(1, 3);
    tick(3);
    chk("R3", "no pulses", int'(countVal), 0);
    extCount = 1'b1;
    tick(2);
    chk("R3", "before sync", int'(countVal), 0);
    tick(1);
    chk("R3", "first rise", int'(countVal), 1);
    tick(5);
    chk("R3", "level high", int'(countVal), 1);
    extCount = 1'b0;
    tick(5);
    chk("R3", "falling", int'(countVal), 1);
    extCount = 1'b1;
    tick(3);
    chk("R3", "second rise", int'(countVal), 2);
    wr(1, 0);
    extCount = 1'b0;
    tick(3);
  endtask

  // R4 R5
  task automatic testTrigSel();
    wr(0, 32); wr(1, 3);
    tick(2);
    chk("R4", "soft start ignored", int'(running), 0);
    extTrig = 1'b1;
    tick(2);
    chk("R4", "rise latency", int'(running), 0);
    tick(1);
    chk("R4", "rise start", int'(running), 1);
    chk("R4", "rise start count", int'(countVal), 0);
    tick(4);
    extTrig = 1'b0;
    tick(3);
    chk("R4", "fall unselected", int'(countVal), 7);
    wr(1, 0);
    wr(0, 64); wr(1, 1);
    extTrig = 1'b1;
    tick(4);
    chk("R4", "rise unselected", int'(running), 0);
    extTrig = 1'b0;
    tick(3);
    chk("R4", "fall start", int'(running), 1);
    wr(1, 0);
    wr(0, 96); wr(1, 1);
    extTrig = 1'b1;
    tick(3);
    chk("R4", "any start", int'(running), 1);
    chk("R4", "any start count", int'(countVal), 0);
    tick(5);
    extTrig = 1'b0;
    tick(3);
    chk("R5", "no retrigger", int'(countVal), 8);
    wr(1, 0);
  endtask

  // R5
  task automatic testRetrig();
    wr(0, 48); wr(1, 1);
    extTrig = 1'b1;
    tick(3);
    chk("R5", "retrig start", int'(running), 1);
    tick(6);
    extTrig = 1'b0;
    tick(2);
    chk("R5", "count before", int'(countVal), 8);
    extTrig = 1'b1;
    tick(2);
    chk("R5", "count in sync", int'(countVal), 10);
    tick(1);
    chk("R5", "restart clear", int'(countVal), 0);
    tick(1);
    chk("R5", "counting again", int'(countVal), 1);
    wr(1, 0);
    extTrig = 1'b0;
    tick(3);
  endtask

  // R8
  task automatic testOnePulse();
    wr(0, 128); wr(2, 3); wr(3, 1); wr(1, 3);
    tick(3);
    chk("R8", "pulse high", int'(waveOut), 1);
    tick(1);
    chk("R8", "stop upd", int'(updFlag), 1);
    chk("R8", "stopped", int'(running), 0);
    tick(3);
    chk("R8", "held count", int'(countVal), 0);
    chk("R8", "held wave", int'(waveOut), 0);
    wr(1, 3);
    chk("R8", "restart", int'(running), 1);
    tick(2);
    chk("R8", "restart count", int'(countVal), 2);
    wr(1, 0);
  endtask

  // R7
  task automatic testSetOnce();
    wr(0, 8); wr(2, 4); wr(3, 1); wr(1, 3);
    chk("R7", "before match", int'(waveOut), 0);
    tick(2);
    chk("R7", "match", int'(waveOut), 1);
    tick(3);
    chk("R7", "wrap count", int'(countVal), 0);
    chk("R7", "held after wrap", int'(waveOut), 1);
    tick(1);
    chk("R7", "held next period", int'(waveOut), 1);
    wr(1, 0);
    chk("R7", "cleared on disable", int'(waveOut), 0);
  endtask

  // R9
  task automatic testPreload();
    wr(0, 0); wr(2, 9); wr(3, 0); wr(0, 2); wr(1, 3);
    tick(2);
    wr(2, 3);
    tick(3);
    chk("R9", "held limit", int'(countVal), 6);
    tick(4);
    chk("R9", "old wrap", int'(countVal), 0);
    chk("R9", "old wrap upd", int'(updFlag), 1);
    tick(3);
    chk("R9", "new limit reached", int'(countVal), 3);
    tick(1);
    chk("R9", "new wrap", int'(updFlag), 1);
    tick(3);
    wr(2, 2);
    chk("R9", "coincident wrap", int'(updFlag), 1);
    tick(3);
    chk("R9", "deferred one more", int'(countVal), 3);
    tick(1);
    chk("R9", "deferred wrap", int'(countVal), 0);
    tick(2);
    chk("R9", "late limit", int'(countVal), 2);
    tick(1);
    chk("R9", "late wrap", int'(updFlag), 1);
    wr(1, 0);
    wr(0, 0); wr(2, 9); wr(1, 3);
    tick(2);
    wr(2, 4);
    tick(1);
    chk("R9", "immediate at limit", int'(countVal), 4);
    tick(1);
    chk("R9", "immediate wrap", int'(updFlag), 1);
    wr(1, 0);
  endtask

  // R10
  task automatic testCfgLock();
    wr(0, 0); wr(1, 1);
    wr(0, 4);
    wr(1, 0);
    chk("R10", "cfg write ignored", int'(waveOut), 0);
    wr(0, 4);
    chk("R10", "cfg write taken", int'(waveOut), 1);
    wr(0, 0);
  endtask

  initial begin
    tick(4);
    rstN = 1'b1;
    tick(1);
    testReset();
    testPwm();
    testPolarity();
    testExtCount();
    testTrigSel();
    testRetrig();
    testOnePulse();
    testSetOnce();
    testPreload();
    testCfgLock();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule